// File: doc/BRIEF.md
# CPU to 16-bit System Bus Cycle Adapter

This block connects a 32-bit processor that uses an asynchronous, dynamically sized bus to a slower 16-bit host bus with separate upper and lower byte strobes. Each processor cycle is decoded by address and function code. The block then does one of three things:

- It runs a paced system bus cycle.
- It hands the cycle to local memory or boot ROM at full speed.
- For sync-driven interrupt levels, it answers the interrupt acknowledge itself with an autovector request.

Acknowledges from the system bus come back through a two-stage synchronizer. The block turns them into the processor's port-size acknowledge pair:

- An 8-bit acknowledge for the byte-wide coprocessor host port, so the processor splits wide accesses into byte cycles.
- A 16-bit acknowledge for every other system region.

From reset the block keeps the on-board processor in halt. It drives the bus-mode select low. It starts a system cycle only when the grant chain position it sits on hands it the bus.

All ports are active high. `cpu_dsack` is `{16-bit ack, 8-bit ack}`.

Top module: `cpu_sysbus_bridge`

## Requirements
- R1: During a system cycle the strobes follow address bit 0 and the size code (01 byte, 10 word, 11 three-byte, 00 long). Odd address: lower strobe only. Even address with byte size: upper strobe only. Even address with any other size: both strobes.
- R2: A system cycle to an ordinary region ends with `cpu_dsack` = 2'b10 once the system acknowledge arrives.
- R3: A system cycle to the host-port window (addresses 0xFFA200 to 0xFFA21F of the low 24 bits, upper byte zero) ends with `cpu_dsack` = 2'b01.
- R4: An interrupt acknowledge is a cycle with function code 111 and address bits 19..16 all ones. At levels 2 and 4 (address bits 3..1) it asserts `cpu_avec` and drives no system strobe.
- R5: An interrupt acknowledge at any other level runs a system cycle and ends with `cpu_dsack` = 2'b10.
- R6: System strobes are launched only on a pacing tick. The ticks occur every SYS_DIV clocks from reset release.
- R7: A local region ends with `cpu_dsack` = 2'b11 after `local_ack`, with no system strobe and no pacing wait. Local regions are an address with a nonzero upper byte, or low-24-bit address bits 23..20 equal to 0xE.
- R8: Within one clock after `cpu_as` falls, all strobes, `cpu_dsack` and `cpu_avec` are low. A new strobe never rises while an acknowledge is still held.
- R9: No system cycle starts while `sys_granted` is low.
- R10: `onboard_halt` is high during and after reset, and `cpu_bmode` is low.
- R11: `sys_dtack` passes through two flip-flops, so a system acknowledge reaches `cpu_dsack` no sooner than three clocks after the strobe launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-side clock |
| rst_n | input | 1 | Active-low reset |
| cpu_as | input | 1 | Processor address strobe |
| cpu_rw | input | 1 | Processor read (1) / write (0) |
| cpu_siz | input | 2 | Transfer size code |
| cpu_fc | input | 3 | Function code |
| cpu_addr | input | 32 | Processor address |
| sys_dtack | input | 1 | System transfer acknowledge, asynchronous |
| sys_granted | input | 1 | Bus granted through the grant chain position |
| local_ack | input | 1 | Local memory/ROM done |
| sys_as | output | 1 | System address strobe |
| sys_rw | output | 1 | System read/write |
| sys_uds | output | 1 | Upper data strobe |
| sys_lds | output | 1 | Lower data strobe |
| cpu_dsack | output | 2 | Port-size acknowledge {16-bit, 8-bit} |
| cpu_avec | output | 1 | Autovector request |
| local_sel | output | 1 | Local memory/ROM cycle select |
| onboard_halt | output | 1 | Holds on-board processor halted |
| cpu_bmode | output | 1 | Bus-mode select, held low |

## Verification
The following are checked on every clock:

- The strobe pattern against address bit 0 and size.
- Launches that fall on a pacing tick while the bus is granted with no acknowledge held.
- Prompt release after the address strobe falls.
- The two-clock synchronizer delay.
- That only a host-port address can produce the 8-bit acknowledge.
- That the autovector never comes with a system strobe.
- That the halt stays asserted.

Only the bench's scenarios can show the following:

- That every size and alignment in each region returns the right acknowledge code.
- That levels 2 and 4 autovector while level 6 does not.
- That local cycles finish without waiting for pacing.
- That strobe launches keep a fixed phase across the whole run.

// File: rtl/cpubr_pkg.sv
package cpubr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_BUS,
    ST_LOC,
    ST_HOLD
  } br_state_e;

  typedef enum logic [1:0] {
    RG_SYS,
    RG_HOST8,
    RG_LOCAL,
    RG_AUTOV
  } region_e;

  localparam logic [1:0] ACK_W16 = 2'b10;
  localparam logic [1:0] ACK_B8  = 2'b01;
  localparam logic [1:0] ACK_L32 = 2'b11;
  localparam logic [1:0] SIZ_BYTE = 2'b01;

  // Returns {upper, lower} data strobes for an access.
  function automatic logic [1:0] strobe_pair(input logic a0, input logic [1:0] siz);
    logic [1:0] s;
    if (a0)                  s = 2'b01;
    else if (siz == SIZ_BYTE) s = 2'b10;
    else                     s = 2'b11;
    return s;
  endfunction

  // Levels served only by the sync sources get an autovector.
  function automatic logic is_autovec_level(input logic [2:0] lvl);
    return (lvl == 3'd2) || (lvl == 3'd4);
  endfunction

endpackage

// File: rtl/br_sync.sv
module br_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/br_pacer.sv
module br_pacer #(
  parameter int DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/br_region_dec.sv
module br_region_dec
  import cpubr_pkg::*;
#(
  parameter int          AW          = 32,
  parameter logic [23:0] HP_BASE     = 24'hFFA200,
  parameter int          HP_SPAN_LOG = 5,
  parameter logic [3:0]  ROM_NIBBLE  = 4'hE
) (
  input  logic [AW-1:0] addr,
  input  logic [2:0]    fc,
  output region_e       region,
  output logic          hp_hit,
  output logic          iack_hit
);
  logic hi_nonzero;
  logic rom_hit;

  assign hi_nonzero = |addr[AW-1:24];
  assign rom_hit    = (addr[23:20] == ROM_NIBBLE);
  assign iack_hit   = (fc == 3'b111) && (addr[19:16] == 4'hF);
  assign hp_hit     = !hi_nonzero && !iack_hit &&
                      (addr[23:HP_SPAN_LOG] == HP_BASE[23:HP_SPAN_LOG]);

  always_comb begin
    if (iack_hit)
      region = is_autovec_level(addr[3:1]) ? RG_AUTOV : RG_SYS;
    else if (hi_nonzero || rom_hit)
      region = RG_LOCAL;
    else if (hp_hit)
      region = RG_HOST8;
    else
      region = RG_SYS;
  end
endmodule

// File: rtl/cpu_sysbus_bridge.sv
module cpu_sysbus_bridge
  import cpubr_pkg::*;
#(
  parameter int SYS_DIV     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_as,
  input  logic        cpu_rw,
  input  logic [1:0]  cpu_siz,
  input  logic [2:0]  cpu_fc,
  input  logic [31:0] cpu_addr,
  input  logic        sys_dtack,
  input  logic        sys_granted,
  input  logic        local_ack,
  output logic        sys_as,
  output logic        sys_rw,
  output logic        sys_uds,
  output logic        sys_lds,
  output logic [1:0]  cpu_dsack,
  output logic        cpu_avec,
  output logic        local_sel,
  output logic        onboard_halt,
  output logic        cpu_bmode
);
  br_state_e state;
  region_e   region;
  logic      hp_hit, iack_hit;
  logic      hp_q;
  logic      pace_tick;
  logic      dtk_s;
  logic      ev_launch;
  logic      ev_sys_ack;

  br_region_dec u_dec (
    .addr     (cpu_addr),
    .fc       (cpu_fc),
    .region   (region),
    .hp_hit   (hp_hit),
    .iack_hit (iack_hit)
  );

  br_pacer #(.DIV(SYS_DIV)) u_pace (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (pace_tick)
  );

  br_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sys_dtack),
    .q     (dtk_s)
  );

  // Named events for the checker.
  assign ev_launch  = cpu_as && (state == ST_WAIT) && pace_tick && sys_granted && !dtk_s;
  assign ev_sys_ack = cpu_as && (state == ST_BUS) && dtk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sys_as    <= 1'b0;
      sys_rw    <= 1'b1;
      sys_uds   <= 1'b0;
      sys_lds   <= 1'b0;
      cpu_dsack <= 2'b00;
      cpu_avec  <= 1'b0;
      local_sel <= 1'b0;
      hp_q      <= 1'b0;
    end else if (!cpu_as) begin
      state     <= ST_IDLE;
      sys_as    <= 1'b0;
      sys_rw    <= 1'b1;
      sys_uds   <= 1'b0;
      sys_lds   <= 1'b0;
      cpu_dsack <= 2'b00;
      cpu_avec  <= 1'b0;
      local_sel <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          hp_q <= (region == RG_HOST8);
          unique case (region)
            RG_AUTOV: begin
              cpu_avec <= 1'b1;
              state    <= ST_HOLD;
            end
            RG_LOCAL: begin
              local_sel <= 1'b1;
              state     <= ST_LOC;
            end
            default: state <= ST_WAIT;
          endcase
        end
        ST_WAIT: begin
          if (ev_launch) begin
            sys_as             <= 1'b1;
            sys_rw             <= cpu_rw;
            {sys_uds, sys_lds} <= strobe_pair(cpu_addr[0], cpu_siz);
            state              <= ST_BUS;
          end
        end
        ST_BUS: begin
          if (ev_sys_ack) begin
            cpu_dsack <= hp_q ? ACK_B8 : ACK_W16;
            state     <= ST_HOLD;
          end
        end
        ST_LOC: begin
          if (local_ack) begin
            cpu_dsack <= ACK_L32;
            state     <= ST_HOLD;
          end
        end
        default: state <= ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) onboard_halt <= 1'b1;
    else        onboard_halt <= 1'b1;
  end

  assign cpu_bmode = 1'b0;
endmodule

// File: rtl/br_chk.sv
module br_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_as,
  input logic [1:0]  cpu_siz,
  input logic [31:0] cpu_addr,
  input logic        sys_dtack,
  input logic        sys_granted,
  input logic        sys_as,
  input logic        sys_uds,
  input logic        sys_lds,
  input logic [1:0]  cpu_dsack,
  input logic        cpu_avec,
  input logic        onboard_halt,
  input logic        pace_tick,
  input logic        dtk_s,
  input logic        hp_hit
);
  // R1
  strobe_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_as |-> (sys_uds == !cpu_addr[0]));
  // R1
  strobe_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_as |-> (sys_lds == (cpu_addr[0] || (cpu_siz != 2'b01))));
  // R3
  byte_ack_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_dsack == 2'b01) |-> hp_hit);
  // R4
  avec_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_avec |-> (!sys_as && !sys_uds && !sys_lds && cpu_dsack == 2'b00));
  // R6
  launch_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_as) |-> $past(pace_tick));
  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_as |=> (cpu_dsack == 2'b00 && !sys_as && !sys_uds && !sys_lds && !cpu_avec));
  // R8
  no_strobe_over_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_as) |-> ($past(cpu_dsack) == 2'b00));
  // R9
  launch_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_as) |-> $past(sys_granted));
  // R10
  halt_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    onboard_halt);
  // R11
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dtk_s) |-> $past(sys_dtack, 2));
endmodule

bind cpu_sysbus_bridge br_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_as       (cpu_as),
  .cpu_siz      (cpu_siz),
  .cpu_addr     (cpu_addr),
  .sys_dtack    (sys_dtack),
  .sys_granted  (sys_granted),
  .sys_as       (sys_as),
  .sys_uds      (sys_uds),
  .sys_lds      (sys_lds),
  .cpu_dsack    (cpu_dsack),
  .cpu_avec     (cpu_avec),
  .onboard_halt (onboard_halt),
  .pace_tick    (pace_tick),
  .dtk_s        (dtk_s),
  .hp_hit       (hp_hit)
);

// File: tb/test_cpu_sysbus_bridge.sv
module test_cpu_sysbus_bridge;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_as, cpu_rw, sys_dtack, sys_granted, local_ack;
  logic [1:0]  cpu_siz;
  logic [2:0]  cpu_fc;
  logic [31:0] cpu_addr;
  logic        sys_as, sys_rw, sys_uds, sys_lds, cpu_avec, local_sel, onboard_halt, cpu_bmode;
  logic [1:0]  cpu_dsack;

  cpu_sysbus_bridge #(.SYS_DIV(DIV)) i_cpu_sysbus_bridge (.*);

  always #2 clk = ~clk;

  typedef struct {
    logic [5:0] exp;   // {uds, lds, dsack[1:0], avec, local_sel}
    string      req;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit seen = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Bus models: system device and local memory respond one clock later.
  initial forever begin
    @(posedge clk); #1;
    sys_dtack = sys_as;
    local_ack = local_sel;
  end

  initial forever @(posedge clk) cyc++;

  // Monitor: scoreboard compare, pacing phase and synchronizer latency.
  initial begin
    int t0 = -1;
    int rise = 0;
    bit prev_as = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (sys_as && !prev_as) begin
          rise = cyc;
          if (t0 < 0) t0 = cyc;
          else chk(((cyc - t0) % DIV) == 0, "R6", "launch phase", cyc - t0, 0);
        end
        prev_as = sys_as;
        if (!seen && (cpu_dsack != 2'b00 || cpu_avec)) begin
          seen = 1;
          if (q.size() == 0) chk(0, "R2", "unexpected response", {cpu_dsack, cpu_avec}, 0);
          else begin
            item_t it;
            it = q.pop_front();
            chk({sys_uds, sys_lds, cpu_dsack, cpu_avec, local_sel} == it.exp, it.req,
                "response", {sys_uds, sys_lds, cpu_dsack, cpu_avec, local_sel}, it.exp);
            if (sys_as) chk((cyc - rise) >= 3, "R11", "sync latency", cyc - rise, 3);
          end
        end
        if (!cpu_as) seen = 0;
      end
    end
  end

  task automatic run_cycle(input logic [31:0] a, input logic [1:0] siz, input logic [2:0] fc,
                           input logic [5:0] exp, input string req);
    item_t it;
    it.exp = exp;
    it.req = req;
    q.push_back(it);
    @(posedge clk); #1;
    cpu_addr = a; cpu_siz = siz; cpu_fc = fc; cpu_rw = 1'b1; cpu_as = 1'b1;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (cpu_dsack != 2'b00 || cpu_avec) break;
    end
    @(posedge clk); #1;
    cpu_as = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk({sys_as, sys_uds, sys_lds, cpu_dsack, cpu_avec} == 6'd0, "R8", "release",
        {sys_as, sys_uds, sys_lds, cpu_dsack, cpu_avec}, 0);
  endtask

  function automatic logic [1:0] exp_strobes(input logic a0, input logic [1:0] siz);
    // Odd: lower only; even byte: upper only; else both (R1).
    return {!a0, a0 | (siz != 2'b01)};
  endfunction

  initial begin
    rst_n = 0; cpu_as = 0; cpu_rw = 1; cpu_siz = 0; cpu_fc = 3'b101; cpu_addr = 0;
    sys_dtack = 0; local_ack = 0; sys_granted = 1;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R10: reset state
    chk(onboard_halt == 1'b1 && cpu_bmode == 1'b0, "R10", "halt/bmode",
        {onboard_halt, cpu_bmode}, 2'b10);
    chk({sys_as, cpu_dsack, cpu_avec, local_sel} == 0, "R8", "idle outputs",
        {sys_as, cpu_dsack, cpu_avec, local_sel}, 0);

    // R1/R2: ordinary region, every size and alignment
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 4; a++)
        run_cycle(32'h00FF_8240 + a, 2'(s), 3'b101,
                  {exp_strobes(a[0], 2'(s)), 2'b10, 1'b0, 1'b0}, "R1/R2");

    // R3: host-port window, byte acknowledge
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 4; a++)
        run_cycle(32'h00FF_A204 + a, 2'(s), 3'b101,
                  {exp_strobes(a[0], 2'(s)), 2'b01, 1'b0, 1'b0}, "R3");

    // R7: local memory and boot ROM
    run_cycle(32'h0100_0000, 2'b00, 3'b101, 6'b00_11_0_1, "R7");
    run_cycle(32'h00E0_0010, 2'b10, 3'b110, 6'b00_11_0_1, "R7");

    // R4: autovector levels 2 and 4
    run_cycle(32'h000F_FFF0 | (2 << 1) | 1, 2'b01, 3'b111, 6'b00_00_1_0, "R4");
    run_cycle(32'h000F_FFF0 | (4 << 1) | 1, 2'b01, 3'b111, 6'b00_00_1_0, "R4");
    // R5: vectored level 6 and 5
    run_cycle(32'h000F_FFF0 | (6 << 1) | 1, 2'b01, 3'b111, 6'b01_10_0_0, "R5");
    run_cycle(32'h000F_FFF0 | (5 << 1) | 1, 2'b01, 3'b111, 6'b01_10_0_0, "R5");

    // R9: no launch while the grant is withheld
    sys_granted = 0;
    fork
      run_cycle(32'h00FF_8000, 2'b10, 3'b101, 6'b11_10_0_0, "R9");
      begin
        for (int k = 0; k < 20; k++) begin
          @(negedge clk);
          chk(sys_as == 1'b0, "R9", "strobe without grant", sys_as, 0);
        end
        @(posedge clk); #1 sys_granted = 1;
      end
    join

    chk(q.size() == 0, "R2", "items left in queue", q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL R8 watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule